// File: doc/BRIEF.md
# Processor Reset Supervisor with Lock-up Watchdog

This block drives the active-low master reset of an embedded processor. When power comes up, or whenever the power-good input is low, it holds the reset line asserted. Once power is good, it keeps reset asserted for a fixed number of strobes from a slow reference (about 83 Hz), and then releases it. With the default of three strobes, the hold time is in the tens of milliseconds.

While the processor runs, the block watches an interrupt request line that a healthy program keeps toggling. A separate, slower reference (about 3 Hz) advances a lock-up counter, and any edge on the watched line clears that counter. If a full window of strobes passes with no edge, the block asserts reset again. That reset lasts as long as the power-on interval, and it is then released.

A one-bit cause output reports whether the most recent reset came from power or from lock-up. Both reference strobes must be one system clock wide and synchronous to the system clock. The watched interrupt line may be asynchronous.

Top module: `cpu_reset_supervisor`

## Requirements
- R1: While `arst_n` is low, `cpu_rst_n` is low and `rst_cause` is 0. After any clock cycle in which `pwr_good` is low, `cpu_rst_n` is low and `rst_cause` is 0 (0 = power, 1 = lock-up).
- R2: With `pwr_good` high, `cpu_rst_n` goes high on the clock edge that samples the HOLD_TICKS-th `slow_tick` strobe of the reset interval. Strobes sampled while `pwr_good` is low are not counted.
- R3: While `cpu_rst_n` is high, each `wd_tick` strobe advances the lock-up count. The edge that samples the WD_TICKS-th strobe with no intervening `irq_mon` edge drives `cpu_rst_n` low and sets `rst_cause` to 1.
- R4: Any rising or falling edge on `irq_mon` clears the lock-up count. The edge is seen through a two-flop synchroniser, so it takes effect at the third clock edge after the change. If it arrives together with the strobe that would have expired the window, the count is cleared and no reset occurs.
- R5: A lock-up reset is released after HOLD_TICKS `slow_tick` strobes. After release, the lock-up count starts again from zero.
- R6: While `cpu_rst_n` is low, `wd_tick` strobes and `irq_mon` edges have no effect on the reset length, and they leave no lock-up count behind.
- R7: `rst_cause` changes only when a reset interval is entered. A `pwr_good` drop during a lock-up reset changes it to 0.
- R8: While `cpu_rst_n` is high, `slow_tick` strobes have no effect on the reset output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low block reset, released synchronously inside |
| pwr_good | input | 1 | High when supply is stable; low forces a power reset |
| slow_tick | input | 1 | One-cycle strobe of the slow reference, times the reset length |
| wd_tick | input | 1 | One-cycle strobe of the slower reference, times the lock-up window |
| irq_mon | input | 1 | Interrupt line watched for activity, may be asynchronous |
| cpu_rst_n | output | 1 | Active-low processor reset |
| rst_cause | output | 1 | Source of the last reset: 0 power, 1 lock-up |

## Verification
The bound checker checks these rules on every cycle:
- a power drop always forces reset and a power cause;
- a release happens only on a sampled slow strobe with power good;
- an assertion of reset while running comes only from a power drop or a watchdog strobe, and in the watchdog case it carries the lock-up cause;
- the cause never changes while the processor runs.

The exact counts fall to the bench's scenarios and its cycle-accurate model. These are:
- the number of strobes before release;
- the eight-strobe window;
- the clearing effect of a synchronised edge that meets the expiring strobe;
- the restart of the count after a lock-up reset.

// File: rtl/cpu_rst_pkg.sv
package cpu_rst_pkg;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } sup_state_e;

  typedef enum logic {
    CAUSE_POWER  = 1'b0,
    CAUSE_LOCKUP = 1'b1
  } rst_cause_e;

endpackage

// File: rtl/rst_release_sync.sv
// Asynchronous assertion, synchronous release of the block reset.
module rst_release_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end else begin : g_single
      always_comb chain_d = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/rst_edge_sync.sv
// Synchronises an asynchronous line and flags any change of level.
module rst_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic edge_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              last_q;
  logic              last_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_comb sync_d = {sync_q[STAGES-2:0], din};
    end else begin : g_single
      always_comb sync_d = din;
    end
  endgenerate

  always_comb last_d = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign edge_o = sync_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/rst_tick_counter.sv
// Counts enable strobes modulo LIMIT; clear has priority.
module rst_tick_counter #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic at_last
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (adv) begin
      if (cnt_q == LAST_VAL) cnt_d = '0;
      else                   cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_last = (cnt_q == LAST_VAL);

endmodule

// File: rtl/cpu_reset_supervisor.sv
module cpu_reset_supervisor #(
  parameter int HOLD_TICKS  = 3,
  parameter int WD_TICKS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic pwr_good,
  input  logic slow_tick,
  input  logic wd_tick,
  input  logic irq_mon,
  output logic cpu_rst_n,
  output logic rst_cause
);

  import cpu_rst_pkg::*;

  logic       rst_int_n;
  logic       irq_edge;
  logic       hold_last;
  logic       wd_last;
  logic       hold_clr;
  logic       hold_adv;
  logic       wd_clr;
  logic       wd_adv;
  logic       hold_done;
  logic       wd_expire;
  sup_state_e state_q;
  sup_state_e state_d;
  rst_cause_e cause_q;
  rst_cause_e cause_d;

  rst_release_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .arst_n     (arst_n),
    .rst_sync_n (rst_int_n)
  );

  rst_edge_sync #(.STAGES(SYNC_STAGES)) u_irq_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .din    (irq_mon),
    .edge_o (irq_edge)
  );

  // Reset-interval counter: runs on slow strobes only while held and powered.
  always_comb begin
    hold_clr = (state_q == ST_RUN) || !pwr_good;
    hold_adv = (state_q == ST_HOLD) && pwr_good && slow_tick;
  end

  rst_tick_counter #(.LIMIT(HOLD_TICKS)) u_hold_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (hold_clr),
    .adv     (hold_adv),
    .at_last (hold_last)
  );

  // Lock-up counter: frozen and cleared while reset is asserted.
  always_comb begin
    wd_clr = (state_q == ST_HOLD) || !pwr_good || irq_edge;
    wd_adv = (state_q == ST_RUN) && wd_tick;
  end

  rst_tick_counter #(.LIMIT(WD_TICKS)) u_wd_cnt (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .clr     (wd_clr),
    .adv     (wd_adv),
    .at_last (wd_last)
  );

  always_comb begin
    hold_done = hold_adv && hold_last;
    wd_expire = wd_adv && wd_last && !irq_edge;
  end

  // Next state and cause.
  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    unique case (state_q)
      ST_HOLD: begin
        if (!pwr_good)      cause_d = CAUSE_POWER;
        else if (hold_done) state_d = ST_RUN;
      end
      ST_RUN: begin
        if (!pwr_good) begin
          state_d = ST_HOLD;
          cause_d = CAUSE_POWER;
        end else if (wd_expire) begin
          state_d = ST_HOLD;
          cause_d = CAUSE_LOCKUP;
        end
      end
      default: state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_HOLD;
      cause_q <= CAUSE_POWER;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
    end
  end

  assign cpu_rst_n = (state_q == ST_RUN);
  assign rst_cause = cause_q;

endmodule

// File: rtl/cpu_reset_supervisor_chk.sv
module cpu_reset_supervisor_chk (
  input logic clk,
  input logic arst_n,
  input logic pwr_good,
  input logic slow_tick,
  input logic wd_tick,
  input logic cpu_rst_n,
  input logic rst_cause
);

  // R1
  pwr_drop_resets_chk: assert property (@(posedge clk) disable iff (!arst_n)
    !pwr_good |=> (!cpu_rst_n && !rst_cause));

  // R2
  release_on_strobe_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(cpu_rst_n) |-> ($past(slow_tick) && $past(pwr_good)));

  // R3
  assert_has_reason_chk: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(cpu_rst_n) |-> ($past(wd_tick) || !$past(pwr_good)));

  // R3
  lockup_cause_chk: assert property (@(posedge clk) disable iff (!arst_n)
    ($fell(cpu_rst_n) && $past(pwr_good)) |-> rst_cause);

  // R6
  held_without_strobe_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (!cpu_rst_n && !slow_tick) |=> !cpu_rst_n);

  // R7
  cause_steady_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (cpu_rst_n && $past(cpu_rst_n)) |-> $stable(rst_cause));

  // R8
  run_ignores_slow_chk: assert property (@(posedge clk) disable iff (!arst_n)
    (cpu_rst_n && pwr_good && !wd_tick) |=> cpu_rst_n);

endmodule

bind cpu_reset_supervisor cpu_reset_supervisor_chk u_chk (
  .clk       (clk),
  .arst_n    (arst_n),
  .pwr_good  (pwr_good),
  .slow_tick (slow_tick),
  .wd_tick   (wd_tick),
  .cpu_rst_n (cpu_rst_n),
  .rst_cause (rst_cause)
);

// File: tb/cpu_reset_supervisor_bench.sv
`timescale 1ns/1ps
module cpu_reset_supervisor_bench;

  localparam int HOLD = 3;
  localparam int WD   = 8;
  localparam int MAX_CYCLES = 20000;

  logic clk = 1'b0;
  logic arst_n, pwr_good, slow_tick, wd_tick, irq_mon;
  logic cpu_rst_n, rst_cause;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cpu_reset_supervisor #(.HOLD_TICKS(HOLD), .WD_TICKS(WD), .SYNC_STAGES(2)) u_cpu_reset_supervisor (
    .clk(clk), .arst_n(arst_n), .pwr_good(pwr_good), .slow_tick(slow_tick),
    .wd_tick(wd_tick), .irq_mon(irq_mon), .cpu_rst_n(cpu_rst_n), .rst_cause(rst_cause)
  );

  // Behavioural reference model
  int m_rel, m_hold, m_wd;
  bit m_run, m_cause;
  bit h0, h1, h2;

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_rel = 0; m_hold = 0; m_wd = 0; m_run = 0; m_cause = 0;
      h0 = 0; h1 = 0; h2 = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit seen;
      seen = (h1 != h2);
      if (!m_run) begin
        m_wd = 0;
        if (!pwr_good) begin
          m_hold = 0; m_cause = 0;
        end else if (slow_tick) begin
          if (m_hold == HOLD - 1) begin m_run = 1; m_hold = 0; end
          else m_hold++;
        end
      end else begin
        m_hold = 0;
        if (!pwr_good) begin
          m_run = 0; m_cause = 0; m_wd = 0;
        end else if (seen) begin
          m_wd = 0;
        end else if (wd_tick) begin
          if (m_wd == WD - 1) begin m_run = 0; m_cause = 1; m_wd = 0; end
          else m_wd++;
        end
      end
      h2 = h1; h1 = h0; h0 = irq_mon;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // Per-cycle comparison against the model (R1 R2 R3 R4 R5 R6 R7 R8)
  always @(negedge clk) begin
    if (!done) begin
      chk("model reset R2", cpu_rst_n, m_run);
      chk("model cause R7", rst_cause, m_cause);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > MAX_CYCLES && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, MAX_CYCLES);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_slow();
    slow_tick = 1'b1; @(negedge clk); slow_tick = 1'b0;
  endtask
  task automatic pulse_wd();
    wd_tick = 1'b1; @(negedge clk); wd_tick = 1'b0;
  endtask
  task automatic toggle_irq();
    irq_mon = ~irq_mon; @(negedge clk);
  endtask

  initial begin
    arst_n = 0; pwr_good = 0; slow_tick = 0; wd_tick = 0; irq_mon = 0;
    idle(4);
    chk("R1 reset low", cpu_rst_n, 1'b0);
    chk("R1 cause power", rst_cause, 1'b0);
    arst_n = 1;
    idle(4);
    pulse_slow();            // ignored: power not good
    chk("R1 held while pwr low", cpu_rst_n, 1'b0);
    pwr_good = 1;
    idle(1);
    pulse_slow(); pulse_slow();
    chk("R2 still held after two strobes", cpu_rst_n, 1'b0);
    pulse_slow();
    chk("R2 released on third strobe", cpu_rst_n, 1'b1);
    // R8
    pulse_slow(); pulse_slow(); pulse_slow(); pulse_slow();
    chk("R8 slow strobes ignored while running", cpu_rst_n, 1'b1);
    // R4 edge clears a partial count
    for (int i = 0; i < 7; i++) pulse_wd();
    chk("R3 seven strobes not enough", cpu_rst_n, 1'b1);
    toggle_irq(); idle(2);
    for (int i = 0; i < 7; i++) pulse_wd();
    chk("R4 count cleared by edge", cpu_rst_n, 1'b1);
    pulse_wd();
    chk("R3 lock-up asserts reset", cpu_rst_n, 1'b0);
    chk("R3 cause lock-up", rst_cause, 1'b1);
    // R6 activity during reset
    for (int i = 0; i < 10; i++) begin pulse_wd(); toggle_irq(); end
    pulse_slow(); pulse_slow();
    chk("R6 hold length unchanged", cpu_rst_n, 1'b0);
    pulse_slow();
    chk("R5 lock-up reset released", cpu_rst_n, 1'b1);
    chk("R7 cause kept after release", rst_cause, 1'b1);
    idle(3);
    for (int i = 0; i < 7; i++) pulse_wd();
    chk("R5 count restarted from zero", cpu_rst_n, 1'b1);
    // R4 edge meeting the expiring strobe
    toggle_irq(); idle(1); pulse_wd();
    chk("R4 edge beats expiring strobe", cpu_rst_n, 1'b1);
    for (int i = 0; i < 7; i++) pulse_wd();
    chk("R4 window restarted", cpu_rst_n, 1'b1);
    pulse_wd();
    chk("R3 second lock-up", cpu_rst_n, 1'b0);
    // R7 power drop during lock-up reset
    pwr_good = 0; idle(1);
    chk("R7 cause becomes power", rst_cause, 1'b0);
    chk("R1 low during power drop", cpu_rst_n, 1'b0);
    pwr_good = 1; idle(1);
    pulse_slow(); pulse_slow(); pulse_slow();
    chk("R2 release after power return", cpu_rst_n, 1'b1);
    chk("R7 cause power after release", rst_cause, 1'b0);
    pwr_good = 0; idle(1);
    chk("R1 power drop while running", cpu_rst_n, 1'b0);
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule